// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block carries out the entry into an interrupt or exception handler. One cycle of `entryReq` hands it the handler gate, the current machine state and the stack pointers for inner privilege levels. It then issues an ordered series of commands, each a stack push, a segment-register load or a stack-pointer set, on a simple held-until-acknowledged interface. When the handler's code segment has been loaded, it reports the new CS, instruction pointer and privilege level.

The block counts nested faults. A fault raised while an earlier entry is still unresolved is turned into a double fault. A third one produces a reset request. A push rejected by the memory side aborts the entry and counts as a further fault. A task gate does not start a sequence. It only raises a task-switch request for a separate unit.

Top module: `intentry_seq`

## Requirements
- R1: Each entry with `isFault`=1 increments a fault counter. When the incremented value exceeds 1, the vector becomes 8 (double fault) and `entryVec` reports 8. When it reaches 3, `resetReq` pulses instead of any command and the counter returns to 0.
- R2: The counter is cleared only by a completed entry (`entryDone`). Software entries (`isFault`=0) do not increment it.
- R3: In protected mode, when the CPL is numerically greater than the handler selector's RPL (bits 1:0), or in V86 mode, the block loads SS from the inner stack of level RPL, sets the stack pointer to that level's inner pointer, and then pushes the old SS and the old ESP.
- R4: On entry from V86 mode, `vmClear` pulses together with the first command. The block pushes GS, FS, DS and ES, then loads GS, FS, DS and ES with 0, all before the stack switch of R3. The pushed EFLAGS has bit 17 cleared.
- R5: Every non-task entry then pushes EFLAGS, CS and the instruction pointer, optionally the error code, and finally loads CS with the handler selector. `entryDone` pulses in the cycle after that load is acknowledged, and `newCs`, `newEip` and `newCpl` are valid with it.
- R6: The error code is pushed only for a fault in protected mode whose effective vector is one of 8, 10, 11, 12, 13, 14 or 17.
- R7: `ifClear` pulses with `entryDone` for gate types 0 (16-bit interrupt) and 2 (32-bit interrupt) and in real mode. It does not pulse for type 1 (16-bit trap) or type 3 (32-bit trap).
- R8: A 32-bit gate (type 2 or 3) gives `newEip` equal to the full gate offset and 32-bit pushes (`cmdWide`=1). A 16-bit gate replaces only bits 15:0 of the old EIP and pushes 16-bit values, zero-extended on `cmdData`.
- R9: In real mode (`protMode`=0), `gateOff` is the vector-table word: bits 31:16 form the selector and bits 15:0 the offset. All pushes are 16 bits wide.
- R10: In protected mode, gate type 4 (task gate) pulses `taskReq` two cycles after the request and issues no command.
- R11: A command stays on `cmdValid`/`cmdKind`/`cmdSeg`/`cmdData`/`cmdWide` unchanged until `cmdAck`. When `cmdAck` comes with `cmdErr`, the entry aborts with `entryAbort` and the fault counter is incremented, as in R1 (reaching 3 also pulses `resetReq`). Command kinds: 0 push, 1 segment load, 2 stack-pointer set. Segment codes: 0 none, 1 ES, 2 CS, 3 SS, 4 DS, 5 FS, 6 GS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| entryReq | input | 1 | Start an entry (sampled when idle) |
| isFault | input | 1 | Entry is a fault rather than a software interrupt |
| vecIn | input | 8 | Vector number |
| errCode | input | 32 | Error code value |
| protMode | input | 1 | Protected mode enabled |
| curCpl | input | 2 | Current privilege level |
| v86Mode | input | 1 | V86 mode active |
| gateSel | input | 16 | Handler selector from the gate |
| gateOff | input | 32 | Gate offset, or real-mode vector word |
| gateType | input | 3 | 0 int16, 1 trap16, 2 int32, 3 trap32, 4 task |
| curEflags | input | 32 | Current flags |
| curCs | input | 16 | Current code selector |
| curEip | input | 32 | Instruction pointer to save |
| curSs | input | 16 | Current stack selector |
| curEsp | input | 32 | Current stack pointer |
| segEs | input | 16 | ES selector |
| segDs | input | 16 | DS selector |
| segFs | input | 16 | FS selector |
| segGs | input | 16 | GS selector |
| innerSsBus | input | 48 | Inner stack selectors, level n at bits 16n+15:16n |
| innerEspBus | input | 96 | Inner stack pointers, level n at bits 32n+31:32n |
| cmdValid | output | 1 | Command present |
| cmdKind | output | 2 | Command kind |
| cmdSeg | output | 3 | Segment register code |
| cmdData | output | 32 | Pushed value, selector or stack pointer |
| cmdWide | output | 1 | Push is 32 bits wide |
| cmdAck | input | 1 | Command accepted |
| cmdErr | input | 1 | Command failed (with cmdAck) |
| busy | output | 1 | Entry in progress |
| entryDone | output | 1 | Entry completed pulse |
| entryAbort | output | 1 | Entry aborted pulse |
| taskReq | output | 1 | Task-switch request pulse |
| resetReq | output | 1 | Triple-fault reset request pulse |
| ifClear | output | 1 | Clear interrupt flag pulse |
| vmClear | output | 1 | Clear V86 flag pulse |
| entryVec | output | 8 | Effective vector of the last entry |
| newCs | output | 16 | Handler code selector |
| newEip | output | 32 | Handler instruction pointer |
| newCpl | output | 2 | New privilege level |

## Verification
The bench targets fault nesting. One aborted software entry followed by a fault must deliver vector 8 with an error code. A design that counts software entries, or forgets that an abort counts as a fault, reports the original vector or misses the reset. The triple fault is reached both at a request and at an abort, and the bench then expects no commands.

The push order is checked in three variants: same level, privilege change, and V86 with its extra selector pushes and null loads. A swapped pair or a stack switch placed before the V86 pushes shows up as a command mismatch.

The 16-bit gate and real mode are exercised so that a design that writes the full offset, or pushes 32-bit values, is caught on `newEip` and `cmdWide`. Trap gates are checked for leaving the interrupt flag alone.

// File: rtl/intentry_pkg.sv
package intentry_pkg;
  typedef enum logic [1:0] {K_PUSH = 2'd0, K_LOAD = 2'd1, K_SETSP = 2'd2} cmd_kind_e;

  localparam logic [2:0] SEG_NONE = 3'd0;
  localparam logic [2:0] SEG_ES   = 3'd1;
  localparam logic [2:0] SEG_CS   = 3'd2;
  localparam logic [2:0] SEG_SS   = 3'd3;
  localparam logic [2:0] SEG_DS   = 3'd4;
  localparam logic [2:0] SEG_FS   = 3'd5;
  localparam logic [2:0] SEG_GS   = 3'd6;

  // Order matters: the controller advances by one through this list.
  typedef enum logic [4:0] {
    C_PGS, C_PFS, C_PDS, C_PES, C_LGS, C_LFS, C_LDS, C_LES,
    C_LSS, C_SSP, C_PSS, C_PSP, C_PFL, C_PCS, C_PIP, C_PERR, C_LCS
  } step_e;

  typedef struct packed {
    logic       latch;
    logic [7:0] vecEff;
    step_e      step;
  } ctl_s;
endpackage

// File: rtl/intentry_ctrl.sv
module intentry_ctrl import intentry_pkg::*; #(
  parameter int DF_VEC     = 8,
  parameter int TRIPLE_CNT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       entryReq,
  input  logic       isFault,
  input  logic [7:0] vecIn,
  input  logic       privChg,
  input  logic       v86Entry,
  input  logic       needErr,
  input  logic       isTask,
  input  logic       cmdAck,
  input  logic       cmdErr,
  output ctl_s       ctl,
  output logic       cmdValid,
  output logic       busy,
  output logic       entryDone,
  output logic       entryAbort,
  output logic       taskReq,
  output logic       resetReq,
  output logic       vmClear
);
  localparam int CNT_W = $clog2(TRIPLE_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_TRIPLE = CNT_W'(TRIPLE_CNT);

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_CMD} state_e;

  state_e           state;
  step_e            step;
  logic [CNT_W-1:0] faultCnt;
  logic [CNT_W-1:0] cntInc;
  step_e            nextStep;

  assign cntInc = faultCnt + 1'b1;

  always_comb begin
    ctl.latch  = (state == S_IDLE) && entryReq;
    ctl.vecEff = (isFault && (cntInc > CNT_W'(1))) ? 8'(DF_VEC) : vecIn;
    ctl.step   = step;
  end

  always_comb begin
    case (step)
      C_PIP:   nextStep = needErr ? C_PERR : C_LCS;
      C_PERR:  nextStep = C_LCS;
      default: nextStep = step_e'(step + 5'd1);
    endcase
  end

  assign cmdValid = (state == S_CMD);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      step       <= C_PFL;
      faultCnt   <= '0;
      entryDone  <= 1'b0;
      entryAbort <= 1'b0;
      taskReq    <= 1'b0;
      resetReq   <= 1'b0;
      vmClear    <= 1'b0;
    end else begin
      entryDone  <= 1'b0;
      entryAbort <= 1'b0;
      taskReq    <= 1'b0;
      resetReq   <= 1'b0;
      vmClear    <= 1'b0;
      case (state)
        S_IDLE: if (entryReq) begin
          if (isFault && (cntInc == CNT_TRIPLE)) begin
            resetReq <= 1'b1;
            faultCnt <= '0;
          end else begin
            if (isFault) faultCnt <= cntInc;
            state <= S_DEC;
          end
        end
        S_DEC: begin
          if (isTask) begin
            taskReq <= 1'b1;
            state   <= S_IDLE;
          end else begin
            state   <= S_CMD;
            vmClear <= v86Entry;
            step    <= v86Entry ? C_PGS : (privChg ? C_LSS : C_PFL);
          end
        end
        S_CMD: if (cmdAck) begin
          if (cmdErr) begin
            entryAbort <= 1'b1;
            state      <= S_IDLE;
            if (cntInc == CNT_TRIPLE) begin
              resetReq <= 1'b1;
              faultCnt <= '0;
            end else begin
              faultCnt <= cntInc;
            end
          end else if (step == C_LCS) begin
            entryDone <= 1'b1;
            faultCnt  <= '0;
            state     <= S_IDLE;
          end else begin
            step <= nextStep;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intentry_dp.sv
module intentry_dp import intentry_pkg::*; #(
  parameter int          SEL_W    = 16,
  parameter int          ADDR_W   = 32,
  parameter int          NLVL     = 3,
  parameter int          VM_BIT   = 17,
  parameter logic [31:0] ERR_MASK = 32'h0002_7D00
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_s                     ctl,
  input  logic                     isFault,
  input  logic [ADDR_W-1:0]        errCode,
  input  logic                     protMode,
  input  logic [1:0]               curCpl,
  input  logic                     v86Mode,
  input  logic [SEL_W-1:0]         gateSel,
  input  logic [ADDR_W-1:0]        gateOff,
  input  logic [2:0]               gateType,
  input  logic [ADDR_W-1:0]        curEflags,
  input  logic [SEL_W-1:0]         curCs,
  input  logic [ADDR_W-1:0]        curEip,
  input  logic [SEL_W-1:0]         curSs,
  input  logic [ADDR_W-1:0]        curEsp,
  input  logic [SEL_W-1:0]         segEs,
  input  logic [SEL_W-1:0]         segDs,
  input  logic [SEL_W-1:0]         segFs,
  input  logic [SEL_W-1:0]         segGs,
  input  logic [NLVL*SEL_W-1:0]    innerSsBus,
  input  logic [NLVL*ADDR_W-1:0]   innerEspBus,
  output logic                     privChg,
  output logic                     v86Entry,
  output logic                     needErr,
  output logic                     isTask,
  output logic                     intGate,
  output logic [1:0]               cmdKind,
  output logic [2:0]               cmdSeg,
  output logic [ADDR_W-1:0]        cmdData,
  output logic                     cmdWide,
  output logic [7:0]               entryVec,
  output logic [SEL_W-1:0]         newCs,
  output logic [ADDR_W-1:0]        newEip,
  output logic [1:0]               newCpl
);
  localparam logic [1:0] LVL_MAX = 2'(NLVL - 1);

  logic [SEL_W-1:0]  ssArr [NLVL];
  logic [ADDR_W-1:0] spArr [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign ssArr[g] = innerSsBus[g*SEL_W +: SEL_W];
    assign spArr[g] = innerEspBus[g*ADDR_W +: ADDR_W];
  end

  logic [1:0] rpl, lvlIdx;
  logic       wideGate, privNow;
  assign rpl      = gateSel[1:0];
  assign lvlIdx   = (rpl > LVL_MAX) ? LVL_MAX : rpl;
  assign wideGate = protMode && ((gateType == 3'd2) || (gateType == 3'd3));
  assign privNow  = protMode && ((curCpl > rpl) || v86Mode);

  logic              rG32;
  logic [SEL_W-1:0]  rSel, rCs, rSs, rEs, rDs, rFs, rGs, rInSs;
  logic [ADDR_W-1:0] rOff, rEip, rEsp, rEfl, rErr, rInEsp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {rG32, intGate, isTask, v86Entry, privChg, needErr} <= '0;
      {rSel, rCs, rSs, rEs, rDs, rFs, rGs, rInSs} <= '0;
      {rOff, rEip, rEsp, rEfl, rErr, rInEsp} <= '0;
      entryVec <= '0;
      newCpl   <= '0;
    end else if (ctl.latch) begin
      rG32     <= wideGate;
      intGate  <= !protMode || (gateType == 3'd0) || (gateType == 3'd2);
      isTask   <= protMode && (gateType == 3'd4);
      v86Entry <= protMode && v86Mode;
      privChg  <= privNow;
      needErr  <= isFault && protMode && (ctl.vecEff[7:5] == 3'd0)
                  && ERR_MASK[ctl.vecEff[4:0]];
      entryVec <= ctl.vecEff;
      newCpl   <= privNow ? rpl : curCpl;
      rSel     <= protMode ? gateSel : gateOff[2*SEL_W-1:SEL_W];
      rOff     <= protMode ? gateOff : ADDR_W'(gateOff[SEL_W-1:0]);
      rEfl     <= curEflags & ~(ADDR_W'(protMode && v86Mode) << VM_BIT);
      rCs      <= curCs;
      rEip     <= curEip;
      rSs      <= curSs;
      rEsp     <= curEsp;
      rEs      <= segEs;
      rDs      <= segDs;
      rFs      <= segFs;
      rGs      <= segGs;
      rErr     <= errCode;
      rInSs    <= ssArr[lvlIdx];
      rInEsp   <= spArr[lvlIdx];
    end
  end

  cmd_kind_e         kind;
  logic [ADDR_W-1:0] raw;

  always_comb begin
    kind   = K_PUSH;
    cmdSeg = SEG_NONE;
    raw    = '0;
    case (ctl.step)
      C_PGS:  begin cmdSeg = SEG_GS; raw = ADDR_W'(rGs); end
      C_PFS:  begin cmdSeg = SEG_FS; raw = ADDR_W'(rFs); end
      C_PDS:  begin cmdSeg = SEG_DS; raw = ADDR_W'(rDs); end
      C_PES:  begin cmdSeg = SEG_ES; raw = ADDR_W'(rEs); end
      C_LGS:  begin kind = K_LOAD; cmdSeg = SEG_GS; end
      C_LFS:  begin kind = K_LOAD; cmdSeg = SEG_FS; end
      C_LDS:  begin kind = K_LOAD; cmdSeg = SEG_DS; end
      C_LES:  begin kind = K_LOAD; cmdSeg = SEG_ES; end
      C_LSS:  begin kind = K_LOAD; cmdSeg = SEG_SS; raw = ADDR_W'(rInSs); end
      C_SSP:  begin kind = K_SETSP; raw = rInEsp; end
      C_PSS:  begin cmdSeg = SEG_SS; raw = ADDR_W'(rSs); end
      C_PSP:  raw = rEsp;
      C_PFL:  raw = rEfl;
      C_PCS:  begin cmdSeg = SEG_CS; raw = ADDR_W'(rCs); end
      C_PIP:  raw = rEip;
      C_PERR: raw = rErr;
      C_LCS:  begin kind = K_LOAD; cmdSeg = SEG_CS; raw = ADDR_W'(rSel); end
      default: raw = '0;
    endcase
  end

  assign cmdKind = kind;
  assign cmdWide = (kind == K_PUSH) && rG32;
  assign cmdData = ((kind == K_PUSH) && !rG32) ? ADDR_W'(raw[SEL_W-1:0]) : raw;
  assign newCs   = rSel;
  assign newEip  = rG32 ? rOff : {rEip[ADDR_W-1:SEL_W], rOff[SEL_W-1:0]};
endmodule

// File: rtl/intentry_seq.sv
module intentry_seq import intentry_pkg::*; #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int NLVL   = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   entryReq,
  input  logic                   isFault,
  input  logic [7:0]             vecIn,
  input  logic [ADDR_W-1:0]      errCode,
  input  logic                   protMode,
  input  logic [1:0]             curCpl,
  input  logic                   v86Mode,
  input  logic [SEL_W-1:0]       gateSel,
  input  logic [ADDR_W-1:0]      gateOff,
  input  logic [2:0]             gateType,
  input  logic [ADDR_W-1:0]      curEflags,
  input  logic [SEL_W-1:0]       curCs,
  input  logic [ADDR_W-1:0]      curEip,
  input  logic [SEL_W-1:0]       curSs,
  input  logic [ADDR_W-1:0]      curEsp,
  input  logic [SEL_W-1:0]       segEs,
  input  logic [SEL_W-1:0]       segDs,
  input  logic [SEL_W-1:0]       segFs,
  input  logic [SEL_W-1:0]       segGs,
  input  logic [NLVL*SEL_W-1:0]  innerSsBus,
  input  logic [NLVL*ADDR_W-1:0] innerEspBus,
  output logic                   cmdValid,
  output logic [1:0]             cmdKind,
  output logic [2:0]             cmdSeg,
  output logic [ADDR_W-1:0]      cmdData,
  output logic                   cmdWide,
  input  logic                   cmdAck,
  input  logic                   cmdErr,
  output logic                   busy,
  output logic                   entryDone,
  output logic                   entryAbort,
  output logic                   taskReq,
  output logic                   resetReq,
  output logic                   ifClear,
  output logic                   vmClear,
  output logic [7:0]             entryVec,
  output logic [SEL_W-1:0]       newCs,
  output logic [ADDR_W-1:0]      newEip,
  output logic [1:0]             newCpl
);
  ctl_s ctl;
  logic privChg, v86Entry, needErr, isTask, intGate;

  intentry_ctrl u_ctrl (
    .clk, .rstN, .entryReq, .isFault, .vecIn,
    .privChg, .v86Entry, .needErr, .isTask,
    .cmdAck, .cmdErr, .ctl, .cmdValid, .busy,
    .entryDone, .entryAbort, .taskReq, .resetReq, .vmClear
  );

  intentry_dp #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .NLVL(NLVL)) u_dp (
    .clk, .rstN, .ctl, .isFault, .errCode, .protMode, .curCpl, .v86Mode,
    .gateSel, .gateOff, .gateType, .curEflags, .curCs, .curEip, .curSs,
    .curEsp, .segEs, .segDs, .segFs, .segGs, .innerSsBus, .innerEspBus,
    .privChg, .v86Entry, .needErr, .isTask, .intGate,
    .cmdKind, .cmdSeg, .cmdData, .cmdWide, .entryVec, .newCs, .newEip, .newCpl
  );

  assign ifClear = entryDone && intGate;
endmodule

// File: rtl/intentry_chk.sv
module intentry_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        cmdAck,
  input logic [1:0]  cmdKind,
  input logic [2:0]  cmdSeg,
  input logic [31:0] cmdData,
  input logic        cmdWide,
  input logic        busy,
  input logic        entryDone,
  input logic        entryAbort,
  input logic        taskReq,
  input logic        resetReq,
  input logic        ifClear,
  input logic        vmClear
);
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdAck |=> cmdValid && $stable(cmdData) && $stable(cmdKind)
                            && $stable(cmdSeg) && $stable(cmdWide));

  p_single_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({entryDone, entryAbort, taskReq}));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> !busy && !cmdValid);

  p_ifclr_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    ifClear |-> entryDone);

  p_vm_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    vmClear |-> cmdValid && cmdKind == 2'd0 && cmdSeg == 3'd6);

  p_task_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    taskReq |-> !busy && !cmdValid);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !cmdValid);
endmodule

bind intentry_seq intentry_chk u_chk (.*);

// File: tb/tb_intentry_seq.sv
`timescale 1ns/1ps
module tb_intentry_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic entryReq = 0, isFault = 0, protMode = 0, v86Mode = 0;
  logic [7:0] vecIn = 0;
  logic [31:0] errCode = 32'h0000_00A5;
  logic [1:0] curCpl = 0;
  logic [15:0] gateSel = 0;
  logic [31:0] gateOff = 0;
  logic [2:0] gateType = 0;
  logic [31:0] curEflags = 32'h0000_0246;
  logic [15:0] curCs = 16'h1234, curSs = 16'h0FF0;
  logic [31:0] curEip = 32'hCAFE_5678, curEsp = 32'h0000_8000;
  logic [15:0] segEs = 16'h0011, segDs = 16'h0022, segFs = 16'h0033, segGs = 16'h0044;
  logic [47:0] innerSsBus = {16'h0028, 16'h0018, 16'h0010};
  logic [95:0] innerEspBus = {32'h0000_D000, 32'h0000_E000, 32'h0000_F000};
  logic cmdAck = 0, cmdErr = 0;
  logic cmdValid, cmdWide, busy, entryDone, entryAbort, taskReq, resetReq, ifClear, vmClear;
  logic [1:0] cmdKind, newCpl;
  logic [2:0] cmdSeg;
  logic [31:0] cmdData, newEip;
  logic [7:0] entryVec;
  logic [15:0] newCs;

  intentry_seq dut (.*);

  int checks = 0, fails = 0;
  int fc = 0;
  logic [37:0] expQ[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [37:0] mk(input int k, input int s, input bit w, input logic [31:0] d);
    return {2'(k), 3'(s), w, (k == 0 && !w) ? {16'h0, d[15:0]} : d};
  endfunction

  function automatic bit errVec(input logic [7:0] v);
    return v == 8 || v == 10 || v == 11 || v == 12 || v == 13 || v == 14 || v == 17;
  endfunction

  task automatic runEntry(input string tag, input bit flt, input logic [7:0] vec, input bit pm,
                          input logic [1:0] cpl, input bit v86, input logic [15:0] sel,
                          input logic [31:0] off, input logic [2:0] gt, input int failIdx,
                          input int lat);
    bit expReset = 0, expTask = 0, expAbort = 0, expDone = 0, priv, w, ve, vmSeen = 0;
    logic [7:0] vecEff;
    logic [1:0] rpl = sel[1:0];
    logic [15:0] expCs;
    logic [31:0] expEip, efl;
    int idx = 0, waitCnt = 0, cyc = 0;
    bit ackNow = 0, ended = 0;
    string endName = "none";
    expQ.delete();
    efl = v86 ? 32'h0002_0202 : 32'h0000_0246;
    if (flt) fc++;
    vecEff = (flt && fc > 1) ? 8'd8 : vec;
    if (flt && fc == 3) begin expReset = 1; fc = 0; end
    else if (pm && gt == 3'd4) expTask = 1;
    else begin
      priv = pm && (cpl > rpl || v86);
      w = pm && (gt == 3'd2 || gt == 3'd3);
      ve = pm && v86;
      if (ve) begin
        expQ.push_back(mk(0, 6, w, 32'h44)); expQ.push_back(mk(0, 5, w, 32'h33));
        expQ.push_back(mk(0, 4, w, 32'h22)); expQ.push_back(mk(0, 1, w, 32'h11));
        expQ.push_back(mk(1, 6, 0, 0)); expQ.push_back(mk(1, 5, 0, 0));
        expQ.push_back(mk(1, 4, 0, 0)); expQ.push_back(mk(1, 1, 0, 0));
      end
      if (priv) begin
        expQ.push_back(mk(1, 3, 0, 32'(innerSsBus[rpl*16 +: 16])));
        expQ.push_back(mk(2, 0, 0, innerEspBus[rpl*32 +: 32]));
        expQ.push_back(mk(0, 3, w, 32'h0FF0));
        expQ.push_back(mk(0, 0, w, 32'h0000_8000));
      end
      expQ.push_back(mk(0, 0, w, ve ? (efl & ~32'h0002_0000) : efl));
      expQ.push_back(mk(0, 2, w, 32'h1234));
      expQ.push_back(mk(0, 0, w, 32'hCAFE_5678));
      if (flt && pm && errVec(vecEff)) expQ.push_back(mk(0, 0, w, 32'h0000_00A5));
      expCs = pm ? sel : off[31:16];
      expQ.push_back(mk(1, 2, 0, 32'(expCs)));
      expEip = w ? off : {16'hCAFE, off[15:0]};
      if (failIdx >= 0) begin
        expAbort = 1; fc++;
        if (fc == 3) begin expReset = 1; fc = 0; end
      end else begin
        expDone = 1; fc = 0;
      end
    end
    @(negedge clk);
    isFault = flt; vecIn = vec; protMode = pm; curCpl = cpl; v86Mode = v86;
    gateSel = sel; gateOff = off; gateType = gt; curEflags = efl; entryReq = 1;
    @(negedge clk);
    entryReq = 0;
    while (!ended && cyc < 200) begin
      if (ackNow) begin
        void'(expQ.pop_front());
        idx++;
        ackNow = 0; cmdAck = 0; cmdErr = 0;
      end
      if (vmClear) vmSeen = 1;
      if (entryDone || entryAbort || taskReq || resetReq) begin
        ended = 1;
        chk({tag, " end done"}, 64'(entryDone), 64'(expDone));
        chk({tag, " end abort"}, 64'(entryAbort), 64'(expAbort));
        chk({tag, " end task R10"}, 64'(taskReq), 64'(expTask));
        chk({tag, " end reset R1"}, 64'(resetReq), 64'(expReset));
        chk({tag, " cmdValid at end"}, 64'(cmdValid), 64'd0);
      end else if (cmdValid) begin
        if (expQ.size() == 0 || (expAbort && idx > failIdx)) begin
          chk({tag, " unexpected command R5"}, 64'(cmdValid), 64'd0);
          ended = 1;
        end else begin
          chk({tag, " command"}, {26'h0, cmdKind, cmdSeg, cmdWide, cmdData}, 64'(expQ[0]));
          waitCnt++;
          if (waitCnt > lat) begin
            ackNow = 1; cmdAck = 1; cmdErr = (idx == failIdx); waitCnt = 0;
          end
        end
      end
      cyc++;
      if (!ended) @(negedge clk);
    end
    if (!ended) chk({tag, " watchdog, no end pulse"}, 64'd0, 64'd1);
    if (expDone) begin
      chk({tag, " queue drained R5"}, 64'(expQ.size()), 64'd0);
      chk({tag, " entryVec R1"}, 64'(entryVec), 64'(vecEff));
      chk({tag, " newCs R9"}, 64'(newCs), 64'(expCs));
      chk({tag, " newEip R8"}, 64'(newEip), 64'(expEip));
      chk({tag, " newCpl R3"}, 64'(newCpl), 64'(priv ? rpl : cpl));
      chk({tag, " ifClear R7"}, 64'(ifClear), 64'(!pm || gt == 3'd0 || gt == 3'd2));
      chk({tag, " vmClear R4"}, 64'(vmSeen), 64'(ve));
    end
    if (expAbort) chk({tag, " abort point R11"}, 64'(idx), 64'(failIdx + 1));
    @(negedge clk);
    chk({tag, " idle after"}, 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset busy", 64'(busy), 0);
    chk("R11 reset cmdValid", 64'(cmdValid), 0);
    chk("R1 reset resetReq", 64'(resetReq), 0);
    rstN = 1;
    // R9 real-mode software interrupt
    runEntry("R9 real sw", 0, 8'h21, 0, 2'd0, 0, 16'h0, 32'h2000_0100, 3'd0, -1, 0);
    // R6 R8 protected fault, same level, 32-bit interrupt gate; R2 not double-faulted
    runEntry("R6 pm fault13", 1, 8'd13, 1, 2'd0, 0, 16'h0008, 32'h0040_1000, 3'd2, -1, 1);
    // R3 privilege change, 16-bit trap gate
    runEntry("R3 trap16 priv", 0, 8'h30, 1, 2'd3, 0, 16'h0010, 32'h0000_3344, 3'd1, -1, 0);
    // R4 V86 entry
    runEntry("R4 v86 fault14", 1, 8'd14, 1, 2'd3, 1, 16'h0008, 32'h0050_0000, 3'd2, -1, 2);
    // R10 task gate
    runEntry("R10 task", 0, 8'h40, 1, 2'd0, 0, 16'h0038, 32'h0, 3'd4, -1, 0);
    // R11 abort counts as a fault, then R1 double fault with error code
    runEntry("R11 sw abort", 0, 8'h41, 1, 2'd0, 0, 16'h0008, 32'h0000_1000, 3'd2, 1, 0);
    runEntry("R1 double fault", 1, 8'd6, 1, 2'd0, 0, 16'h0008, 32'h0000_2000, 3'd2, -1, 0);
    // R6 real-mode fault: no error code
    runEntry("R6 real fault13", 1, 8'd13, 0, 2'd0, 0, 16'h0, 32'h3000_0200, 3'd0, -1, 1);
    // R1 triple at request
    runEntry("R1 abortA", 0, 8'h42, 1, 2'd0, 0, 16'h0008, 32'h0, 3'd2, 0, 0);
    runEntry("R1 abortB", 0, 8'h43, 1, 2'd0, 0, 16'h0008, 32'h0, 3'd2, 2, 0);
    runEntry("R1 triple", 1, 8'd13, 1, 2'd0, 0, 16'h0008, 32'h0, 3'd2, -1, 0);
    // R11 triple reached by an abort
    runEntry("R11 abortC", 0, 8'h44, 1, 2'd0, 0, 16'h0008, 32'h0, 3'd2, 0, 0);
    runEntry("R11 abort to reset", 1, 8'd13, 1, 2'd0, 0, 16'h0008, 32'h0, 3'd2, 0, 0);
    // R7 32-bit trap gate keeps IF; R2 counter cleared after success
    runEntry("R7 trap32", 1, 8'd10, 1, 2'd1, 0, 16'h0019, 32'h0060_0000, 3'd3, -1, 0);
    runEntry("R2 fresh fault", 1, 8'd13, 1, 2'd0, 0, 16'h0008, 32'h0070_0000, 3'd0, -1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule